// File: doc/BRIEF.md
# Low-Power Domain Register Write Bridge

This block sits between a fast system bus and a small bank of registers that is clocked by a slow, always-on clock of about 32 kHz. A CPU write to one of those registers is captured on the bus side. It is handed across the clock boundary with a toggle handshake and a pair of two-flop synchronizers, and it is applied in the slow domain. The slow side then holds off for a fixed guard window of slow cycles and acknowledges back. When the acknowledge arrives, the bus side raises a completion flag. A second slow-domain write that arrives before the acknowledge is thrown away and raises a sticky error flag.

The bridge also holds an interrupt mask register. That register is written directly in the bus domain, with no crossing. The block combines the mask with its status flags to drive one interrupt line. Two external event levels, a clock alarm and a security violation, are shown in the status word and can also raise the interrupt. Reads use the same strobe as writes, and the read data comes back one bus cycle after the strobe.

Top module: `lpw_bridge`

## Requirements
- R1: After reset the status word (address NREG) reads 0x04, which has only the not-busy flag set. The mask register (address NREG+1) reads 0 and `irq` is low.
- R2: A write to a slow register (address below NREG) that is accepted sets busy (status bit 5) and clears not-busy (status bit 2) from the next bus cycle until its transfer completes.
- R3: When a transfer completes, the target slow register holds the written data, busy is clear and write-complete (status bit 0) is set.
- R4: A status read returns the flags as they were before the read, and it clears write-complete. If a completion lands in the same cycle as the read, the flag stays set.
- R5: A slow-register write issued while busy is discarded, leaving the target register unchanged, and it sets write-error (status bit 1).
- R6: Write-error survives status reads. The next accepted slow-register write or mask write clears it.
- R7: A mask write stores bits [4:0] in the next cycle, reads back from address NREG+1, and sets neither busy nor write-complete.
- R8: `irq` is the OR of the status bits [4:0] (write-complete, write-error, not-busy, alarm, violation), each ANDed with the mask bit in the same position.
- R9: `alarm_in` and `viol_in` appear as live levels at status bits 3 and 4.
- R10: Writes to the status address or to any address above NREG+1 change nothing. Reads of unused addresses return 0.
- R11: Every read strobe produces exactly one `bus_rvalid` pulse, in the cycle after the strobe, with its data on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Active-low asynchronous reset, bus domain |
| clk_lp | input | 1 | Slow always-on clock |
| rst_lp_n | input | 1 | Active-low asynchronous reset, slow domain |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| alarm_in | input | 1 | Clock alarm event level |
| viol_in | input | 1 | Security violation event level |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is a status read that falls in the very bus cycle where the acknowledge toggle is detected. If the clear-on-read beat the completion in that cycle, the completion would be lost without any sign. The bench starts a slow write and then holds the read strobe on the status address every cycle. The first reply that shows busy clear must also show write-complete set, whatever the phase between the two free-running clocks turns out to be. Rejected writes are produced by issuing two slow-register writes a couple of bus cycles apart, which is well inside the guard window.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    // status word bit positions (the mask register uses bits [4:0] likewise)
    localparam int ST_WC   = 0;
    localparam int ST_WE   = 1;
    localparam int ST_NB   = 2;
    localparam int ST_ALM  = 3;
    localparam int ST_VIO  = 4;
    localparam int ST_BUSY = 5;
    localparam int IEN_W   = 5;
    localparam int STAT_W  = 6;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LP   = 2'd1,
        ACC_STAT = 2'd2,
        ACC_IEN  = 2'd3
    } acc_e;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/lpw_lp_side.sv
module lpw_lp_side #(
    parameter int NREG   = 4,
    parameter int DATA_W = 32,
    parameter int WINDOW = 4,
    localparam int IDX_W = $clog2(NREG),
    localparam int CNT_W = $clog2(WINDOW + 1)
) (
    input  logic                          clk_lp,
    input  logic                          rst_lp_n,
    input  logic                          req_sync,
    input  logic [IDX_W-1:0]              hold_idx,
    input  logic [DATA_W-1:0]             hold_data,
    output logic                          ack_tgl,
    output logic [NREG-1:0][DATA_W-1:0]   regs
);
    typedef struct packed {
        logic                        seen;
        logic                        active;
        logic [CNT_W-1:0]            cnt;
        logic                        ack;
        logic [NREG-1:0][DATA_W-1:0] regs;
    } lp_st_t;

    lp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == CNT_W'(WINDOW - 1)) begin
                st_d.active = 1'b0;
                st_d.ack    = ~st_q.ack;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (req_sync != st_q.seen) begin
            // hold_idx / hold_data are stable while the bus side is busy
            st_d.seen           = req_sync;
            st_d.active         = 1'b1;
            st_d.cnt            = '0;
            st_d.regs[hold_idx] = hold_data;
        end
    end

    always_ff @(posedge clk_lp or negedge rst_lp_n) begin
        if (!rst_lp_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;
    assign regs    = st_q.regs;
endmodule

// File: rtl/lpw_bus_ctl.sv
module lpw_bus_ctl
    import lpw_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(NREG),
    localparam int ADDR_W = $clog2(NREG + 2)
) (
    input  logic                        clk_bus,
    input  logic                        rst_bus_n,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic                        alarm_in,
    input  logic                        viol_in,
    input  logic                        ack_sync,
    input  logic [NREG-1:0][DATA_W-1:0] lp_regs,
    output logic                        req_tgl,
    output logic [IDX_W-1:0]            hold_idx,
    output logic [DATA_W-1:0]           hold_data,
    output logic                        busy,
    output logic                        wc_flag,
    output logic                        we_flag,
    output logic [IEN_W-1:0]            ien,
    output logic                        irq
);
    typedef struct packed {
        logic              busy;
        logic              wc;
        logic              we;
        logic [IEN_W-1:0]  ien;
        logic              req;
        logic              ack_seen;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } bus_st_t;

    bus_st_t st_d, st_q;
    acc_e    acc;
    logic    done;
    logic [STAT_W-1:0] stat;

    always_comb begin
        if (bus_addr < ADDR_W'(NREG))           acc = ACC_LP;
        else if (bus_addr == ADDR_W'(NREG))     acc = ACC_STAT;
        else if (bus_addr == ADDR_W'(NREG + 1)) acc = ACC_IEN;
        else                                    acc = ACC_NONE;
    end

    always_comb begin
        stat          = '0;
        stat[ST_WC]   = st_q.wc;
        stat[ST_WE]   = st_q.we;
        stat[ST_NB]   = ~st_q.busy;
        stat[ST_ALM]  = alarm_in;
        stat[ST_VIO]  = viol_in;
        stat[ST_BUSY] = st_q.busy;
    end

    assign done = ack_sync ^ st_q.ack_seen;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (bus_valid && !bus_write) begin
            st_d.rvalid = 1'b1;
            unique case (acc)
                ACC_LP:   st_d.rdata = lp_regs[bus_addr[IDX_W-1:0]];
                ACC_STAT: begin
                    st_d.rdata = DATA_W'(stat);
                    st_d.wc    = 1'b0;
                end
                ACC_IEN:  st_d.rdata = DATA_W'(st_q.ien);
                default:  st_d.rdata = '0;
            endcase
        end
        if (bus_valid && bus_write) begin
            unique case (acc)
                ACC_LP: begin
                    if (st_q.busy) begin
                        st_d.we = 1'b1;
                    end else begin
                        st_d.busy = 1'b1;
                        st_d.we   = 1'b0;
                        st_d.req  = ~st_q.req;
                        st_d.idx  = bus_addr[IDX_W-1:0];
                        st_d.data = bus_wdata;
                    end
                end
                ACC_IEN: begin
                    st_d.ien = bus_wdata[IEN_W-1:0];
                    st_d.we  = 1'b0;
                end
                default: ;
            endcase
        end
        // completion after the read clear, so it takes priority
        if (done) begin
            st_d.ack_seen = ack_sync;
            st_d.busy     = 1'b0;
            st_d.wc       = 1'b1;
        end
    end

    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign req_tgl    = st_q.req;
    assign hold_idx   = st_q.idx;
    assign hold_data  = st_q.data;
    assign busy       = st_q.busy;
    assign wc_flag    = st_q.wc;
    assign we_flag    = st_q.we;
    assign ien        = st_q.ien;
    assign irq        = |(stat[IEN_W-1:0] & st_q.ien);
endmodule

// File: rtl/lpw_bridge.sv
module lpw_bridge
    import lpw_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int DATA_W = 32,
    parameter int WINDOW = 4,
    localparam int IDX_W  = $clog2(NREG),
    localparam int ADDR_W = $clog2(NREG + 2)
) (
    input  logic              clk_bus,
    input  logic              rst_bus_n,
    input  logic              clk_lp,
    input  logic              rst_lp_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              alarm_in,
    input  logic              viol_in,
    output logic              irq
);
    logic                        req_tgl, req_sync;
    logic                        ack_tgl, ack_sync;
    logic [IDX_W-1:0]            hold_idx;
    logic [DATA_W-1:0]           hold_data;
    logic [NREG-1:0][DATA_W-1:0] lp_regs;
    logic                        busy_w, wc_w, we_w;
    logic [IEN_W-1:0]            ien_w;

    lpw_bus_ctl #(.NREG(NREG), .DATA_W(DATA_W)) bus_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .alarm_in(alarm_in), .viol_in(viol_in),
        .ack_sync(ack_sync), .lp_regs(lp_regs),
        .req_tgl(req_tgl), .hold_idx(hold_idx), .hold_data(hold_data),
        .busy(busy_w), .wc_flag(wc_w), .we_flag(we_w), .ien(ien_w), .irq(irq)
    );

    lpw_sync #(.W(1)) req_sync_i (
        .clk(clk_lp), .rst_n(rst_lp_n), .din(req_tgl), .dout(req_sync)
    );

    lpw_sync #(.W(1)) ack_sync_i (
        .clk(clk_bus), .rst_n(rst_bus_n), .din(ack_tgl), .dout(ack_sync)
    );

    lpw_lp_side #(.NREG(NREG), .DATA_W(DATA_W), .WINDOW(WINDOW)) lp_i (
        .clk_lp(clk_lp), .rst_lp_n(rst_lp_n),
        .req_sync(req_sync), .hold_idx(hold_idx), .hold_data(hold_data),
        .ack_tgl(ack_tgl), .regs(lp_regs)
    );
endmodule

// File: rtl/lpw_bridge_chk.sv
module lpw_bridge_chk
    import lpw_pkg::*;
#(
    parameter int NREG = 4,
    localparam int ADDR_W = $clog2(NREG + 2)
) (
    input logic              clk_bus,
    input logic              rst_bus_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              busy,
    input logic              wc,
    input logic              we,
    input logic [IEN_W-1:0]  ien,
    input logic              irq
);
    logic wr_lp, wr_ien;
    assign wr_lp  = bus_valid && bus_write && (bus_addr < ADDR_W'(NREG));
    assign wr_ien = bus_valid && bus_write && (bus_addr == ADDR_W'(NREG + 1));

    AST_READ_RVALID: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (bus_valid && !bus_write) |=> bus_rvalid); // R11
    AST_ACCEPT_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_lp && !busy) |=> (busy && !we)); // R2
    AST_REJECT_ERR: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_lp && busy) |=> we); // R5
    AST_ERR_STICKY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (we && !(bus_valid && bus_write)) |=> we); // R6
    AST_IEN_NO_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_ien && !busy) |=> !busy); // R7
    AST_WC_AFTER_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $rose(wc) |-> $past(busy)); // R3
    AST_IRQ_GATED: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (ien == '0) |-> !irq); // R8
endmodule

bind lpw_bridge lpw_bridge_chk #(.NREG(NREG)) chk_i (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid),
    .busy(busy_w), .wc(wc_w), .we(we_w), .ien(ien_w), .irq(irq)
);

// File: tb/lpw_bridge_tb_top.sv
`timescale 1ns/1ps
module lpw_bridge_tb_top;
    localparam int NREG   = 4;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int A_STAT = 4;
    localparam int A_IEN  = 5;

    logic clk_bus = 1'b0, clk_lp = 1'b0;
    logic rst_bus_n = 1'b0, rst_lp_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic bus_rvalid, irq;
    logic alarm_in = 1'b0, viol_in = 1'b0;

    always #2.5 clk_bus = ~clk_bus;   // 200 MHz bus clock
    always #48.3 clk_lp = ~clk_lp;    // scaled-down, unrelated slow clock

    lpw_bridge #(.NREG(NREG), .DATA_W(DW), .WINDOW(4)) dut_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_lp(clk_lp), .rst_lp_n(rst_lp_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .alarm_in(alarm_in), .viol_in(viol_in), .irq(irq)
    );

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;
    int   n_chk = 0, n_err = 0;
    bit   poll_mode = 1'b0;
    bit   done = 1'b0;

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk_bus) begin
        if (rst_bus_n && bus_rvalid && !poll_mode) begin
            if (sb_q.size() == 0) begin
                check("R11 unexpected rvalid", 1, 0);
            end else begin
                cur = sb_q.pop_front();
                check(cur.tag, bus_rdata, cur.exp);
            end
        end
    end

    task automatic bus_wr(int addr, logic [DW-1:0] data);
        @(negedge clk_bus);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk_bus);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(int addr, logic [DW-1:0] exp, string tag);
        exp_t e;
        @(negedge clk_bus);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk_bus);
        bus_valid = 1'b0;
    endtask

    task automatic chk_irq(string tag, logic exp);
        @(negedge clk_bus);
        check(tag, DW'(irq), DW'(exp));
    endtask

    task automatic settle();
        #2000;
        @(negedge clk_bus);
    endtask

    initial begin
        logic [DW-1:0] first;
        bit got;
        #203;
        @(negedge clk_bus);
        rst_bus_n = 1'b1; rst_lp_n = 1'b1;
        repeat (4) @(negedge clk_bus);

        // reset state
        bus_rd(A_STAT, 32'h04, "R1 status after reset");
        bus_rd(A_IEN, 32'h00, "R1 mask after reset");
        chk_irq("R1 irq after reset", 1'b0);

        // basic transfer
        bus_wr(0, 32'hA5A5_0001);
        bus_rd(A_STAT, 32'h20, "R2 busy while in flight");
        settle();
        bus_rd(A_STAT, 32'h05, "R3 complete flag after transfer");
        bus_rd(A_STAT, 32'h04, "R4 complete cleared by status read");
        bus_rd(0, 32'hA5A5_0001, "R3 slow register content");

        // second write too early
        bus_wr(1, 32'h0000_1111);
        bus_wr(2, 32'h0000_2222);
        settle();
        bus_rd(A_STAT, 32'h07, "R5 error set on early write");
        bus_rd(A_STAT, 32'h06, "R6 error survives status read");
        bus_rd(2, 32'h0, "R5 rejected write discarded");
        bus_rd(1, 32'h0000_1111, "R3 first write landed");

        // mask write at bus speed
        bus_wr(A_IEN, 32'hFFFF_FFE1);
        bus_rd(A_STAT, 32'h04, "R7 mask write: no busy, no complete, error cleared R6");
        bus_rd(A_IEN, 32'h01, "R7 mask readback");

        // interrupt on completion
        chk_irq("R8 irq low, complete masked in but clear", 1'b0);
        bus_wr(3, 32'h0000_3333);
        chk_irq("R8 irq low while busy", 1'b0);
        settle();
        chk_irq("R8 irq on complete", 1'b1);
        bus_rd(A_STAT, 32'h05, "R4 status before clear");
        chk_irq("R8 irq drops after status read", 1'b0);

        // ignored writes
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        bus_rd(A_STAT, 32'h04, "R10 status write ignored");
        bus_rd(A_IEN, 32'h01, "R10 mask unchanged by status write");
        bus_wr(6, 32'hDEAD_BEEF);
        bus_rd(6, 32'h0, "R10 unused address reads zero");
        bus_rd(3, 32'h0000_3333, "R10 slow regs unchanged by unused write");

        // event levels
        @(negedge clk_bus); alarm_in = 1'b1;
        bus_rd(A_STAT, 32'h0C, "R9 alarm level in status");
        chk_irq("R8 alarm masked out", 1'b0);
        bus_wr(A_IEN, 32'h08);
        chk_irq("R8 alarm masked in", 1'b1);
        @(negedge clk_bus); alarm_in = 1'b0; viol_in = 1'b1;
        bus_rd(A_STAT, 32'h14, "R9 violation level in status");
        chk_irq("R8 violation masked out", 1'b0);
        bus_wr(A_IEN, 32'h10);
        chk_irq("R8 violation masked in", 1'b1);
        @(negedge clk_bus); viol_in = 1'b0;
        bus_wr(A_IEN, 32'h04);
        chk_irq("R8 not-busy masked in", 1'b1);
        bus_wr(A_IEN, 32'h00);

        // error cleared by accepted slow write
        bus_wr(0, 32'h55);
        bus_wr(1, 32'h66);
        settle();
        bus_rd(A_STAT, 32'h07, "R5 error again");
        bus_wr(2, 32'h77);
        bus_rd(A_STAT, 32'h20, "R6 accepted write clears error");
        settle();
        bus_rd(2, 32'h77, "R3 third register");
        bus_rd(1, 32'h0000_1111, "R5 register untouched by rejected write");
        bus_rd(A_STAT, 32'h05, "R3 complete after third register");

        // continuous status polling across completion
        bus_wr(0, 32'h99);
        poll_mode = 1'b1;
        got = 1'b0;
        first = '0;
        @(negedge clk_bus);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(A_STAT);
        for (int i = 0; i < 800; i++) begin
            @(negedge clk_bus);
            if (bus_rvalid && !bus_rdata[5]) begin
                got = 1'b1;
                first = bus_rdata;
                break;
            end
        end
        bus_valid = 1'b0;
        @(negedge clk_bus);
        @(negedge clk_bus);
        poll_mode = 1'b0;
        check("R4 completion survives same-cycle read", got ? first : 32'hFFFF_FFFF, 32'h05);
        bus_rd(A_STAT, 32'h04, "R4 polled read cleared complete");
        bus_rd(0, 32'h99, "R3 polled write landed");

        repeat (4) @(negedge clk_bus);
        check("R11 no stray rvalid", DW'(bus_rvalid), 0);
        check("R11 all reads returned", DW'(sb_q.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #300000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule